// File: doc/BRIEF.md
# Multiply-accumulate microkernel sequencer for in-memory compute

This block runs a short microkernel that computes a matrix-vector product next to a memory array. A small instruction store holds MAC, JUMP and EXIT words. Once started, the sequencer steps through them. Each MAC waits for a column-access command. The command carries a bank number, a column number and a 256-bit data block, which is read as sixteen signed 16-bit lanes. The MAC multiplies that block lane by lane with one entry of an eight-entry input-vector register file. It adds the products into one entry of an eight-entry accumulator file, sixteen 32-bit lanes per entry.

The accumulator and vector indices normally come from the MAC word. In address-aligned mode they come from the incoming command instead: the bank number picks the accumulator and the column number picks the vector entry. A plain counting loop can then walk all 64 rows of a native tile with a single MAC and a single JUMP. A JUMP placed after a MAC is resolved on the same command that fires the MAC. When the microkernel ends, the accumulators stay readable until they are cleared.

Top module: `pim_mac_seq`

## Requirements
- R1: After reset, busy_o and done_o are low and every accumulator lane reads zero.
- R2: A MAC adds, in each lane l, the signed product of vector lane bits [16l+15:16l] and data lane bits [16l+15:16l] into a 32-bit accumulator that wraps modulo 2^32, which is read at rd_data_o bits [32l+31:32l].
- R3: An instruction with bits [15:14] = 01 is a MAC. When bit 13 is 0, the accumulator index comes from bits [12:10] and the vector index from bits [9:7], and no other accumulator changes.
- R4: When bit 13 of a MAC is 1, the accumulator index is col_bank_i and the vector index is col_addr_i. The instruction fields [12:7] have no effect.
- R5: A MAC takes effect only on a cycle with col_valid_i high while busy_o is high, one accumulation per command. Commands arriving while busy_o is low change no accumulator.
- R6: An instruction with bits [15:14] = 10 is a JUMP with backward distance in bits [13:8] and repeat count in bits [7:0]. A MAC followed by a JUMP with distance 1 and count N runs N+1 times, then execution falls through past the JUMP.
- R7: The repeat counter loads from the count field on each fresh arrival at a JUMP. A second loop after a finished one, or a restart, runs its full count.
- R8: An instruction with bits [15:14] = 00 ends the run: busy_o falls and done_o rises on the next clock. start_i, while not busy, begins execution at address 0 and clears done_o.
- R9: clear_i zeroes every accumulator on the next clock and takes priority over a MAC on the same clock.
- R10: rd_data_o shows the accumulator selected by rd_idx_i without a clock, and it keeps its value after the run ends.
- R11: grf_we_i writes grf_data_i into vector entry grf_idx_i, and prog_we_i writes prog_data_i at instruction address prog_addr_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| prog_we_i | input | 1 | Instruction write enable |
| prog_addr_i | input | 4 | Instruction address |
| prog_data_i | input | 16 | Instruction word |
| grf_we_i | input | 1 | Vector register write enable |
| grf_idx_i | input | 3 | Vector register index |
| grf_data_i | input | 256 | Vector register data, 16 lanes |
| start_i | input | 1 | Begin execution at address 0 |
| clear_i | input | 1 | Zero all accumulators |
| col_valid_i | input | 1 | Column-access command valid |
| col_bank_i | input | 3 | Command bank number |
| col_addr_i | input | 3 | Command column number |
| col_data_i | input | 256 | Command data block, 16 lanes |
| rd_idx_i | input | 3 | Accumulator readout index |
| rd_data_o | output | 512 | Selected accumulator, 16 lanes of 32 bits |
| busy_o | output | 1 | Microkernel running |
| done_o | output | 1 | Microkernel ended |

## Verification
The bench uses the default sizes: sixteen 16-bit lanes, 32-bit accumulators, eight entries in each register file and a sixteen-word instruction store. With these sizes a single MAC and a JUMP with count 63 can fill all eight accumulators across 64 commands, so the full native tile is covered in one run. The 32-bit accumulator width also lets four products of the most negative operand carry past bit 31 and wrap to zero, which exercises the modulo-2^32 rule. Explicit and address-aligned indexing, two loops in sequence and a restart are each run on the same small instruction store.

// File: rtl/pim_mac_pkg.sv
package pim_mac_pkg;
  localparam int INSTR_W = 16;
  localparam int OFF_W   = 6;
  localparam int CNT_W   = 8;

  typedef enum logic [1:0] {
    OP_EXIT = 2'b00,
    OP_MAC  = 2'b01,
    OP_JUMP = 2'b10,
    OP_RSVD = 2'b11
  } op_e;
endpackage

// File: rtl/pim_imem.sv
module pim_imem #(
  parameter int DEPTH = 16,
  parameter int W     = 16,
  localparam int AW_L = $clog2(DEPTH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [AW_L-1:0] waddr_i,
  input  logic [W-1:0]    wdata_i,
  input  logic [AW_L-1:0] raddr_a_i,
  input  logic [AW_L-1:0] raddr_b_i,
  output logic [W-1:0]    rdata_a_o,
  output logic [W-1:0]    rdata_b_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/pim_vreg_file.sv
module pim_vreg_file #(
  parameter int N     = 8,
  parameter int W     = 256,
  localparam int IW   = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] widx_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [IW-1:0] ridx_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] reg_q [N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) reg_q[i] <= '0;
    end else if (we_i) begin
      reg_q[widx_i] <= wdata_i;
    end
  end

  assign rdata_o = reg_q[ridx_i];
endmodule

// File: rtl/pim_acc_file.sv
module pim_acc_file #(
  parameter int NREG  = 8,
  parameter int LANES = 16,
  parameter int EW    = 16,
  parameter int AW    = 32,
  localparam int IW   = $clog2(NREG),
  localparam int DW   = LANES * EW,
  localparam int RW   = LANES * AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          mac_en_i,
  input  logic [IW-1:0] dst_i,
  input  logic [DW-1:0] vec_i,
  input  logic [DW-1:0] blk_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [RW-1:0] rd_data_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic signed [EW-1:0]   a_s, b_s;
    logic signed [2*EW-1:0] prod;
    logic [AW-1:0]          acc_q [NREG];

    assign a_s  = $signed(vec_i[l*EW +: EW]);
    assign b_s  = $signed(blk_i[l*EW +: EW]);
    assign prod = a_s * b_s;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int r = 0; r < NREG; r++) acc_q[r] <= '0;
      end else if (clear_i) begin
        for (int r = 0; r < NREG; r++) acc_q[r] <= '0;
      end else if (mac_en_i) begin
        acc_q[dst_i] <= acc_q[dst_i] + AW'(prod);  // sign-extended, wraps
      end
    end

    assign rd_data_o[l*AW +: AW] = acc_q[rd_idx_i];
  end
endmodule

// File: rtl/pim_seq.sv
module pim_seq
  import pim_mac_pkg::*;
#(
  parameter int IA_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               col_valid_i,
  input  op_e                op_cur_i,
  input  logic [INSTR_W-1:0] instr_nxt_i,
  output logic [IA_W-1:0]    pc_o,
  output logic [IA_W-1:0]    pc_nxt_o,
  output logic               mac_fire_o,
  output logic               busy_o,
  output logic               done_o
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} state_e;

  state_e           state_q;
  logic [IA_W-1:0]  pc_q;
  logic [CNT_W-1:0] cnt_q;
  logic             loop_act_q;

  op_e              op_nxt;
  logic [OFF_W-1:0] off_f;
  logic [CNT_W-1:0] cnt_f;
  logic [IA_W-1:0]  jmp_tgt, pc_skip;

  assign op_nxt  = op_e'(instr_nxt_i[15:14]);
  assign off_f   = instr_nxt_i[13:8];
  assign cnt_f   = instr_nxt_i[7:0];
  assign pc_nxt_o = pc_q + 1'b1;
  assign jmp_tgt = pc_nxt_o - IA_W'(off_f);
  assign pc_skip = pc_nxt_o + 1'b1;

  assign mac_fire_o = (state_q == S_RUN) && (op_cur_i == OP_MAC) && col_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      pc_q       <= '0;
      cnt_q      <= '0;
      loop_act_q <= 1'b0;
    end else begin
      case (state_q)
        S_RUN: begin
          case (op_cur_i)
            OP_MAC: begin
              if (col_valid_i) begin
                if (op_nxt == OP_JUMP) begin
                  if (!loop_act_q) begin
                    // fresh arrival: load count
                    if (cnt_f != '0) begin
                      pc_q       <= jmp_tgt;
                      cnt_q      <= cnt_f - 1'b1;
                      loop_act_q <= 1'b1;
                    end else begin
                      pc_q <= pc_skip;
                    end
                  end else if (cnt_q != '0) begin
                    pc_q  <= jmp_tgt;
                    cnt_q <= cnt_q - 1'b1;
                  end else begin
                    pc_q       <= pc_skip;
                    loop_act_q <= 1'b0;
                  end
                end else begin
                  pc_q <= pc_nxt_o;
                end
              end
            end
            OP_JUMP: pc_q <= pc_nxt_o;  // stray jump not after a MAC: skip
            default: state_q <= S_DONE;
          endcase
        end
        default: begin
          if (start_i) begin
            state_q    <= S_RUN;
            pc_q       <= '0;
            loop_act_q <= 1'b0;
          end
        end
      endcase
    end
  end

  assign pc_o   = pc_q;
  assign busy_o = (state_q == S_RUN);
  assign done_o = (state_q == S_DONE);
endmodule

// File: rtl/pim_mac_seq.sv
module pim_mac_seq
  import pim_mac_pkg::*;
#(
  parameter int LANES      = 16,
  parameter int EW         = 16,
  parameter int AW         = 32,
  parameter int NREG_A     = 8,
  parameter int NREG_B     = 8,
  parameter int IMEM_DEPTH = 16,
  localparam int DW        = LANES * EW,
  localparam int RW        = LANES * AW,
  localparam int AIDX_W    = $clog2(NREG_A),
  localparam int BIDX_W    = $clog2(NREG_B),
  localparam int IA_W      = $clog2(IMEM_DEPTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               prog_we_i,
  input  logic [IA_W-1:0]    prog_addr_i,
  input  logic [INSTR_W-1:0] prog_data_i,
  input  logic               grf_we_i,
  input  logic [AIDX_W-1:0]  grf_idx_i,
  input  logic [DW-1:0]      grf_data_i,
  input  logic               start_i,
  input  logic               clear_i,
  input  logic               col_valid_i,
  input  logic [BIDX_W-1:0]  col_bank_i,
  input  logic [AIDX_W-1:0]  col_addr_i,
  input  logic [DW-1:0]      col_data_i,
  input  logic [BIDX_W-1:0]  rd_idx_i,
  output logic [RW-1:0]      rd_data_o,
  output logic               busy_o,
  output logic               done_o
);
  logic [IA_W-1:0]    pc, pc_nxt;
  logic [INSTR_W-1:0] instr_cur, instr_nxt;
  logic               mac_fire, aam;
  logic [BIDX_W-1:0]  dst_idx;
  logic [AIDX_W-1:0]  src_idx;
  logic [DW-1:0]      vec;

  pim_imem #(.DEPTH(IMEM_DEPTH), .W(INSTR_W)) u_imem (
    .clk_i, .rst_ni,
    .we_i(prog_we_i), .waddr_i(prog_addr_i), .wdata_i(prog_data_i),
    .raddr_a_i(pc), .raddr_b_i(pc_nxt),
    .rdata_a_o(instr_cur), .rdata_b_o(instr_nxt)
  );

  pim_seq #(.IA_W(IA_W)) u_seq (
    .clk_i, .rst_ni,
    .start_i, .col_valid_i,
    .op_cur_i(op_e'(instr_cur[15:14])),
    .instr_nxt_i(instr_nxt),
    .pc_o(pc), .pc_nxt_o(pc_nxt),
    .mac_fire_o(mac_fire),
    .busy_o, .done_o
  );

  // address-aligned mode takes both indices from the command
  assign aam     = instr_cur[13];
  assign dst_idx = aam ? col_bank_i : BIDX_W'(instr_cur[12:10]);
  assign src_idx = aam ? col_addr_i : AIDX_W'(instr_cur[9:7]);

  pim_vreg_file #(.N(NREG_A), .W(DW)) u_grf_a (
    .clk_i, .rst_ni,
    .we_i(grf_we_i), .widx_i(grf_idx_i), .wdata_i(grf_data_i),
    .ridx_i(src_idx), .rdata_o(vec)
  );

  pim_acc_file #(.NREG(NREG_B), .LANES(LANES), .EW(EW), .AW(AW)) u_acc (
    .clk_i, .rst_ni,
    .clear_i, .mac_en_i(mac_fire),
    .dst_i(dst_idx), .vec_i(vec), .blk_i(col_data_i),
    .rd_idx_i, .rd_data_o
  );
endmodule

// File: rtl/pim_mac_seq_chk.sv
module pim_mac_seq_chk #(
  parameter int RW  = 512,
  parameter int IW  = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          clear_i,
  input logic [IW-1:0] rd_idx_i,
  input logic [RW-1:0] rd_data_o,
  input logic          busy_o,
  input logic          done_o
);
  a_r8_busy_done_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));

  a_r8_done_after_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(busy_o));

  a_r8_start_runs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  a_r9_clear_zeroes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (rd_data_o == '0));

  a_r5_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !clear_i) |=> ($stable(rd_data_o) || !$stable(rd_idx_i)));
endmodule

bind pim_mac_seq pim_mac_seq_chk #(.RW(RW), .IW(BIDX_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .clear_i(clear_i),
  .rd_idx_i(rd_idx_i), .rd_data_o(rd_data_o), .busy_o(busy_o), .done_o(done_o)
);

// File: tb/tb_pim_mac_seq.sv
module tb_pim_mac_seq;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 16;
  localparam int DW = 256;
  localparam int RW = 512;
  localparam int WDOG = 20000;

  // {a, b, expected product}
  localparam logic [63:0] VECS [6] = '{
    {16'h0003, 16'h0005, 32'h0000000F},
    {16'hFFFE, 16'h0007, 32'hFFFFFFF2},
    {16'h7FFF, 16'h7FFF, 32'h3FFF0001},
    {16'h8000, 16'h8000, 32'h40000000},
    {16'h8000, 16'h7FFF, 32'hC0008000},
    {16'hFFFF, 16'hFFFF, 32'h00000001}
  };

  logic clk = 0, rst_n = 0;
  logic prog_we = 0, grf_we = 0, start = 0, clear = 0, col_valid = 0;
  logic [3:0] prog_addr = '0;
  logic [15:0] prog_data = '0;
  logic [2:0] grf_idx = '0, col_bank = '0, col_addr = '0, rd_idx = '0;
  logic [DW-1:0] grf_data = '0, col_data = '0;
  logic [RW-1:0] rd_data;
  logic busy, done;
  int checks = 0, errors = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pim_mac_seq dut (
    .clk_i(clk), .rst_ni(rst_n),
    .prog_we_i(prog_we), .prog_addr_i(prog_addr), .prog_data_i(prog_data),
    .grf_we_i(grf_we), .grf_idx_i(grf_idx), .grf_data_i(grf_data),
    .start_i(start), .clear_i(clear),
    .col_valid_i(col_valid), .col_bank_i(col_bank), .col_addr_i(col_addr), .col_data_i(col_data),
    .rd_idx_i(rd_idx), .rd_data_o(rd_data), .busy_o(busy), .done_o(done)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > WDOG) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [DW-1:0] fill(input logic [15:0] v);
    logic [DW-1:0] r;
    for (int l = 0; l < LANES; l++) r[l*16 +: 16] = v;
    return r;
  endfunction

  function automatic logic [DW-1:0] lin(input int mul, input int off);
    logic [DW-1:0] r;
    for (int l = 0; l < LANES; l++) r[l*16 +: 16] = 16'(mul * (l + off));
    return r;
  endfunction

  function automatic logic [15:0] mac_w(input bit aam, input int d, input int s);
    return {2'b01, aam, 3'(d), 3'(s), 7'b0};
  endfunction

  function automatic logic [15:0] jmp_w(input int off, input int cnt);
    return {2'b10, 6'(off), 8'(cnt)};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic load_i(input int a, input logic [15:0] w);
    @(negedge clk); prog_we = 1; prog_addr = 4'(a); prog_data = w;
    @(negedge clk); prog_we = 0;
  endtask

  task automatic load_a(input int idx, input logic [DW-1:0] d);
    @(negedge clk); grf_we = 1; grf_idx = 3'(idx); grf_data = d;
    @(negedge clk); grf_we = 0;
  endtask

  task automatic do_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic do_clear();
    @(negedge clk); clear = 1;
    @(negedge clk); clear = 0;
  endtask

  task automatic cmd(input int bank, input int col, input logic [DW-1:0] d);
    @(negedge clk); col_valid = 1; col_bank = 3'(bank); col_addr = 3'(col); col_data = d;
    @(negedge clk); col_valid = 0;
  endtask

  task automatic chk_lin(input string tag, input int idx, input int mul, input int off);
    rd_idx = 3'(idx); #1;
    for (int l = 0; l < LANES; l++)
      check(tag, rd_data[l*32 +: 32], 32'(mul * (l + off)));
  endtask

  task automatic chk_const(input string tag, input int idx, input logic [31:0] v);
    rd_idx = 3'(idx); #1;
    for (int l = 0; l < LANES; l++) check(tag, rd_data[l*32 +: 32], v);
  endtask

  initial begin
    tick(2);
    #1 rst_n = 1;
    tick(1);
    // R1: reset state
    check("R1 busy", 32'(busy), 0);
    check("R1 done", 32'(done), 0);
    for (int r = 0; r < 8; r++) chk_const("R1 acc zero", r, 32'h0);

    // R2 / R11: lane arithmetic table
    load_i(0, mac_w(0, 0, 0));
    load_i(1, 16'h0000);
    for (int v = 0; v < 6; v++) begin
      do_clear();
      load_a(0, fill(VECS[v][63:48]));
      do_start();
      cmd(0, 0, fill(VECS[v][47:32]));
      tick(2);
      chk_const("R2 product", 0, VECS[v][31:0]);
      check("R8 done", 32'(done), 1);
    end

    // R2 wrap + R6 short loop: four times (-32768)^2 wraps to 0
    do_clear();
    load_a(0, fill(16'h8000));
    load_i(0, mac_w(0, 0, 0));
    load_i(1, jmp_w(1, 3));
    load_i(2, 16'h0000);
    do_start();
    for (int i = 0; i < 3; i++) cmd(0, 0, fill(16'h8000));
    tick(2);
    check("R6 busy mid loop", 32'(busy), 1);
    chk_const("R2 acc before wrap", 0, 32'hC0000000);
    cmd(0, 0, fill(16'h8000));
    tick(2);
    chk_const("R2 wrap", 0, 32'h0);
    check("R6 loop end done", 32'(done), 1);

    // R4 / R6 / R8: 64-row address-aligned tile
    do_clear();
    for (int j = 0; j < 8; j++) load_a(j, fill(16'(j + 1)));
    load_i(0, mac_w(1, 7, 7));
    load_i(1, jmp_w(1, 63));
    load_i(2, 16'h0000);
    do_start();
    for (int i = 0; i < 64; i++) begin
      cmd(i / 8, i % 8, lin(i / 8 + 1, -8));
      if (i == 62) check("R6 busy after 63", 32'(busy), 1);
    end
    tick(2);
    check("R8 busy low", 32'(busy), 0);
    check("R8 done high", 32'(done), 1);
    for (int b = 0; b < 8; b++) chk_lin("R4 tile sum", b, 36 * (b + 1), -8);

    // R5: commands while idle are ignored; R10: readout holds
    cmd(0, 0, fill(16'h0001));
    cmd(3, 2, fill(16'h0100));
    tick(3);
    chk_lin("R5 idle ignored", 0, 36, -8);
    chk_lin("R10 hold", 3, 144, -8);

    // R3 / R7: two loops in sequence, explicit indices
    do_clear();
    load_a(0, fill(16'h0001));
    load_a(3, fill(16'h0005));
    load_i(0, mac_w(0, 1, 0));
    load_i(1, jmp_w(1, 2));
    load_i(2, mac_w(0, 2, 3));
    load_i(3, jmp_w(1, 1));
    load_i(4, 16'h0000);
    do_start();
    for (int i = 0; i < 4; i++) cmd(5, 6, lin(1, 1));
    tick(2);
    check("R7 busy before last", 32'(busy), 1);
    cmd(5, 6, lin(1, 1));
    tick(2);
    check("R7 done", 32'(done), 1);
    chk_lin("R7 first loop", 1, 3, 1);
    chk_lin("R3 second loop src", 2, 10, 1);
    chk_const("R3 other acc", 0, 32'h0);
    chk_const("R3 bank acc untouched", 5, 32'h0);
    // R7: restart reloads counters
    do_start();
    check("R8 done cleared", 32'(done), 0);
    for (int i = 0; i < 5; i++) cmd(0, 0, lin(1, 1));
    tick(2);
    check("R7 restart done", 32'(done), 1);
    chk_lin("R7 restart acc1", 1, 6, 1);
    chk_lin("R7 restart acc2", 2, 20, 1);

    // R9: clear wins over a MAC in the same cycle
    load_a(0, fill(16'h0001));
    load_i(0, mac_w(0, 0, 0));
    load_i(1, 16'h0000);
    do_start();
    @(negedge clk); col_valid = 1; clear = 1; col_data = fill(16'h0009);
    @(negedge clk); col_valid = 0; clear = 0;
    tick(2);
    for (int r = 0; r < 8; r++) chk_const("R9 clear priority", r, 32'h0);
    check("R9 run ended", 32'(done), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule